// File: doc/BRIEF.md
# Four-Way LRU Tag Cache

This block is the tag side of a second-level cache that sits between a smaller upper-level cache and a backing memory. It holds no data, only tags. It keeps 256 sets of 4 ways over 64-byte blocks, which is 64 KB of address coverage. Each set keeps a true least-recently-used order. One read request is in flight at a time. The request address is split into a byte offset (bits 5:0), a set index (bits 13:6, the block number modulo 256) and a tag (the bits above).

After a fixed tag-lookup time the block decides between a hit and a miss. On a hit it makes the way the most recently used one and tells the upper level to fill. On a miss it starts a fixed-latency fetch from memory and counts the access. When the fetch ends, it writes the block into the set and then tells the upper level to fill. The write uses a free way if the set has one. Otherwise it evicts the least recently used way. Memory is modelled as a responder that always accepts and answers after a fixed delay.

The fill notice carries the address of the request and a hit flag. Running counters of hits, misses and memory accesses are visible at the ports.

Top module: `lru_tag_cache`

## Requirements
- R1: The set is chosen by address bits 13:6 and the tag is bits 31:14. Offset bits 5:0 do not affect the outcome, so two addresses in one 64-byte block give the same hit or miss.
- R2: A request accepted at a clock edge that hits raises `resp_valid` for one cycle with `resp_hit`=1, exactly 12 cycles after that edge.
- R3: A request that misses pulses `mem_fetch` for one cycle 12 cycles after acceptance. It then raises `resp_valid` with `resp_hit`=0 exactly 212 cycles after acceptance.
- R4: `req_ready` is high only while idle and falls after every accepted request. A `req_valid` seen while `req_ready` is low is ignored and produces no response.
- R5: A hit makes the way the most recently used in its set, so a block touched after others survives the next eviction.
- R6: A miss writes into a free way when the set has one. In a full set it evicts the least recently used way, and the other three blocks stay resident.
- R7: Blocks 0, 256, 512 and 768 are filled into set 0, then block 1024 is requested. After that, blocks 256, 512 and 768 hit and block 0 misses.
- R8: `hit_count`, `miss_count` and `mem_count` reset to 0. `hit_count` grows by 1 per hit. `miss_count` and `mem_count` each grow by 1 per miss.
- R9: Reset empties every set, so a block that was resident before reset misses afterwards. After reset `req_ready`=1 and `resp_valid`=0.
- R10: `resp_addr` returns the full address of the request being answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 32 | Byte address of the request |
| req_ready | output | 1 | Idle, a request is taken at this edge |
| resp_valid | output | 1 | One-cycle fill notice to the upper level |
| resp_hit | output | 1 | 1 when the notice came from a hit, 0 after a memory fetch |
| resp_addr | output | 32 | Address of the request being answered |
| mem_fetch | output | 1 | One-cycle pulse when a memory fetch starts |
| hit_count | output | 32 | Number of hits |
| miss_count | output | 32 | Number of misses |
| mem_count | output | 32 | Number of memory accesses |

## Verification
Two things can land in one cycle. In a full set, the miss that must pick a victim can coincide with the age update of the three other ways. A promotion by a hit can also be followed closely by an eviction in the same set. The bench provokes both: it fills a set completely, promotes the oldest block with a hit, and then inserts a fifth block. The check is which blocks hit or miss on the accesses that follow. In the same runs a scoreboard compares the hit flag, the address and the exact latency of every fill notice. Requests driven while the block is busy must not appear as extra responses.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_FETCH = 2'd2
  } cache_st_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int SETS  = 256,
  parameter int WAYS  = 4,
  parameter int TAG_W = 18,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_en,
  input  logic [IDX_W-1:0]            rd_idx,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [TAG_W-1:0]            wr_tag,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  output logic [WAYS-1:0]             rd_vld
);
  // Valid bits live in flops so reset can clear them all at once.
  logic [WAYS-1:0] vld [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
      rd_vld <= '0;
    end else begin
      if (wr_en) vld[wr_idx][wr_way] <= 1'b1;
      if (rd_en) rd_vld <= vld[rd_idx];
    end
  end

  // One tag memory per way: a single write port and a registered read port.
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] mem [SETS];
    logic [TAG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == WAY_W'(w))) mem[wr_idx] <= wr_tag;
      if (rd_en) q <= mem[rd_idx];
    end
    assign rd_tag[w] = q;
  end
endmodule

// File: rtl/cache_age_store.sv
module cache_age_store #(
  parameter int SETS  = 256,
  parameter int WAYS  = 4,
  parameter int AGE_W = 2,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                        clk,
  input  logic                        rd_en,
  input  logic [IDX_W-1:0]            rd_idx,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WAYS-1:0][AGE_W-1:0]  wr_age,
  output logic [WAYS-1:0][AGE_W-1:0]  rd_age
);
  // One word per set holding every way's age.
  logic [WAYS*AGE_W-1:0] mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_age;
    if (rd_en) rd_age <= mem[rd_idx];
  end
endmodule

// File: rtl/cache_lru_pick.sv
module cache_lru_pick #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 18,
  parameter int AGE_W = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [WAYS-1:0]             vld,
  input  logic [WAYS-1:0][AGE_W-1:0]  ages,
  input  logic [TAG_W-1:0]            req_tag,
  output logic                        hit,
  output logic [WAY_W-1:0]            touch_way,
  output logic [WAYS-1:0][AGE_W-1:0]  new_ages
);
  logic [WAY_W-1:0] hit_way, vic_way;
  logic [AGE_W:0]   old_eff;

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld[w] && (tags[w] == req_tag)) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
    // Prefer the lowest-numbered free way; in a full set take the oldest.
    vic_way = '0;
    if (&vld) begin
      for (int w = 0; w < WAYS; w++)
        if (ages[w] == AGE_W'(WAYS - 1)) vic_way = WAY_W'(w);
    end else begin
      for (int w = WAYS - 1; w >= 0; w--)
        if (!vld[w]) vic_way = WAY_W'(w);
    end
    touch_way = hit ? hit_way : vic_way;
    // A free way counts as older than every resident one.
    old_eff = vld[touch_way] ? {1'b0, ages[touch_way]} : (AGE_W+1)'(WAYS);
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touch_way)
        new_ages[w] = '0;
      else if (vld[w] && ({1'b0, ages[w]} < old_eff))
        new_ages[w] = ages[w] + AGE_W'(1);
      else
        new_ages[w] = ages[w];
    end
  end
endmodule

// File: rtl/lru_tag_cache.sv
module lru_tag_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64,
  parameter int SETS        = 256,
  parameter int WAYS        = 4,
  parameter int LOOKUP_CYC  = 12,
  parameter int MEM_CYC     = 200,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [ADDR_W-1:0] resp_addr,
  output logic              mem_fetch,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  mem_count
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int AGE_W = WAY_W;
  localparam int TMR_W = $clog2(LOOKUP_CYC + MEM_CYC + 1);

  cache_st_e                  st;
  logic [TMR_W-1:0]           tmr;
  logic [TMR_W-1:0]           lat_q;   // cycles since acceptance, for checks
  logic [ADDR_W-1:0]          addr_q;
  logic [WAY_W-1:0]           pend_way;
  logic [WAYS-1:0][AGE_W-1:0] pend_ages;

  logic                       accept, look_done, fetch_done;
  logic [IDX_W-1:0]           cur_idx;
  logic [TAG_W-1:0]           cur_tag;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0]            rd_vld;
  logic [WAYS-1:0][AGE_W-1:0] rd_age, new_ages, age_wr_d;
  logic                       hit, age_we;
  logic [WAY_W-1:0]           touch_way;

  assign req_ready  = (st == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign look_done  = (st == ST_LOOK)  && (tmr == '0);
  assign fetch_done = (st == ST_FETCH) && (tmr == '0);
  assign cur_idx    = addr_q[OFF_W +: IDX_W];
  assign cur_tag    = addr_q[ADDR_W-1 -: TAG_W];
  assign age_we     = (look_done && hit) || fetch_done;
  assign age_wr_d   = fetch_done ? pend_ages : new_ages;

  cache_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (accept),
    .rd_idx (req_addr[OFF_W +: IDX_W]),
    .wr_en  (fetch_done),
    .wr_idx (cur_idx),
    .wr_way (pend_way),
    .wr_tag (cur_tag),
    .rd_tag (rd_tag),
    .rd_vld (rd_vld)
  );

  cache_age_store #(.SETS(SETS), .WAYS(WAYS), .AGE_W(AGE_W)) u_ages (
    .clk    (clk),
    .rd_en  (accept),
    .rd_idx (req_addr[OFF_W +: IDX_W]),
    .wr_en  (age_we),
    .wr_idx (cur_idx),
    .wr_age (age_wr_d),
    .rd_age (rd_age)
  );

  cache_lru_pick #(.WAYS(WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W)) u_pick (
    .tags      (rd_tag),
    .vld       (rd_vld),
    .ages      (rd_age),
    .req_tag   (cur_tag),
    .hit       (hit),
    .touch_way (touch_way),
    .new_ages  (new_ages)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      tmr        <= '0;
      lat_q      <= '0;
      addr_q     <= '0;
      pend_way   <= '0;
      pend_ages  <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_addr  <= '0;
      mem_fetch  <= 1'b0;
      hit_count  <= '0;
      miss_count <= '0;
      mem_count  <= '0;
    end else begin
      resp_valid <= 1'b0;
      mem_fetch  <= 1'b0;
      if (accept)              lat_q <= '0;
      else if (st != ST_IDLE)  lat_q <= lat_q + TMR_W'(1);
      case (st)
        ST_IDLE: if (accept) begin
          addr_q <= req_addr;
          tmr    <= TMR_W'(LOOKUP_CYC - 1);
          st     <= ST_LOOK;
        end
        ST_LOOK: if (tmr != '0) begin
          tmr <= tmr - TMR_W'(1);
        end else if (hit) begin
          resp_valid <= 1'b1;
          resp_hit   <= 1'b1;
          resp_addr  <= addr_q;
          hit_count  <= hit_count + CNT_W'(1);
          st         <= ST_IDLE;
        end else begin
          miss_count <= miss_count + CNT_W'(1);
          mem_count  <= mem_count + CNT_W'(1);
          mem_fetch  <= 1'b1;
          pend_way   <= touch_way;
          pend_ages  <= new_ages;
          tmr        <= TMR_W'(MEM_CYC - 1);
          st         <= ST_FETCH;
        end
        ST_FETCH: if (tmr != '0) begin
          tmr <= tmr - TMR_W'(1);
        end else begin
          resp_valid <= 1'b1;
          resp_hit   <= 1'b0;
          resp_addr  <= addr_q;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: an accepted request makes the block busy on the next cycle
  a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R2: a hit notice arrives exactly the lookup time after acceptance
  a_r2_hit_latency: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> (lat_q == TMR_W'(LOOKUP_CYC)));

  // R3: a miss notice arrives after lookup plus memory time
  a_r3_miss_latency: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> (lat_q == TMR_W'(LOOKUP_CYC + MEM_CYC)));

  // R3: the fetch starts at the end of the lookup and no notice shares its cycle
  a_r3_fetch_timing: assert property (@(posedge clk) disable iff (rst)
    mem_fetch |-> ((lat_q == TMR_W'(LOOKUP_CYC)) && !resp_valid));

  // R8: hit counter moves only together with a hit notice
  a_r8_hit_count_step: assert property (@(posedge clk) disable iff (rst)
    (hit_count != $past(hit_count)) |-> (resp_valid && resp_hit));

  // R8: memory counter moves only with a fetch pulse
  a_r8_mem_count_step: assert property (@(posedge clk) disable iff (rst)
    (mem_count != $past(mem_count)) |-> mem_fetch);
endmodule

// File: tb/lru_tag_cache_tb.sv
module lru_tag_cache_tb;
  localparam int LOOKUP = 12;
  localparam int MEMLAT = 200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, resp_valid, resp_hit, mem_fetch;
  logic [31:0] resp_addr, hit_count, miss_count, mem_count;

  lru_tag_cache u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_addr(resp_addr), .mem_fetch(mem_fetch), .hit_count(hit_count),
    .miss_count(miss_count), .mem_count(mem_count)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always_ff @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  int acc_cyc = 0, n_fetch = 0, exp_hits = 0, exp_miss = 0;
  bit done = 0;

  logic [31:0] q_addr[$];
  bit          q_hit[$];
  string       q_rq[$];

  task automatic check_eq(string rq, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per fill notice.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (mem_fetch) begin
          n_fetch++;
          check_eq("R3", "fetch pulse delay", cyc - acc_cyc, LOOKUP);
        end
        if (resp_valid) begin
          if (q_hit.size() == 0) begin
            check_eq("R4", "unexpected response count", 1, 0);
          end else begin
            logic [31:0] ea;
            bit          eh;
            string       er;
            ea = q_addr.pop_front();
            eh = q_hit.pop_front();
            er = q_rq.pop_front();
            check_eq(er, "hit flag", resp_hit, eh);
            check_eq("R10", "resp_addr", resp_addr, ea);
            if (eh) check_eq("R2", "hit latency", cyc - acc_cyc, LOOKUP);
            else    check_eq("R3", "miss latency", cyc - acc_cyc, LOOKUP + MEMLAT);
          end
        end
      end
    end
  end

  // Driver: issue one request, push its expectation, wait for the notice.
  task automatic issue(logic [31:0] a, bit want_hit, string rq, bit poke);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    #1;
    acc_cyc   = cyc;
    req_valid = 1'b0;
    q_addr.push_back(a);
    q_hit.push_back(want_hit);
    q_rq.push_back(rq);
    if (want_hit) exp_hits++; else exp_miss++;
    if (poke) begin
      // R4: requests offered while busy must be dropped
      @(negedge clk);
      check_eq("R4", "req_ready while busy", req_ready, 0);
      req_valid = 1'b1;
      req_addr  = a ^ 32'h0000_5000;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (q_hit.size() != 0) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_hits = 0; exp_miss = 0; n_fetch = 0;
    @(negedge clk);
  endtask

  task automatic check_counts(string tag);
    check_eq("R8", {tag, " hit_count"}, hit_count, exp_hits);
    check_eq("R8", {tag, " miss_count"}, miss_count, exp_miss);
    check_eq("R8", {tag, " mem_count"}, mem_count, exp_miss);
    check_eq("R3", {tag, " fetch pulses"}, n_fetch, exp_miss);
  endtask

  initial begin
    do_reset();
    // R9: idle state after reset
    check_eq("R9", "req_ready after reset", req_ready, 1);
    check_eq("R9", "resp_valid after reset", resp_valid, 0);
    check_counts("reset");

    // R7: fill set 0 with four blocks, then a fifth evicts block 0
    issue(32'h0000_0000, 0, "R7", 0);
    issue(32'h0000_4000, 0, "R7", 0);
    issue(32'h0000_8000, 0, "R6", 0);
    issue(32'h0000_C000, 0, "R6", 0);
    issue(32'h0001_0000, 0, "R7", 1);
    issue(32'h0000_4000, 1, "R7", 1);
    issue(32'h0000_8000, 1, "R7", 0);
    issue(32'h0000_C000, 1, "R7", 0);
    issue(32'h0000_0000, 0, "R7", 0);

    // R1: offsets inside a block and a neighbouring set
    issue(32'h0000_403F, 1, "R1", 0);
    issue(32'h0000_4020, 1, "R1", 0);
    issue(32'h0000_0040, 0, "R1", 0);
    issue(32'h0000_007F, 1, "R1", 0);

    // R5/R6: set 5, promote the oldest block, then insert a fifth one
    issue(32'h0000_0140, 0, "R6", 0);
    issue(32'h0000_4140, 0, "R6", 0);
    issue(32'h0000_8140, 0, "R6", 0);
    issue(32'h0000_C140, 0, "R6", 0);
    issue(32'h0000_0140, 1, "R5", 0);
    issue(32'h0001_0140, 0, "R6", 0);
    issue(32'h0000_0140, 1, "R5", 0);
    issue(32'h0000_4140, 0, "R5", 0);
    issue(32'h0000_C140, 1, "R6", 0);
    issue(32'h0000_8140, 0, "R6", 0);

    repeat (3) @(negedge clk);
    check_counts("run");

    // R9: reset forgets resident blocks
    do_reset();
    check_counts("second reset");
    issue(32'h0000_4000, 0, "R9", 0);
    issue(32'h0000_4000, 1, "R9", 0);
    repeat (3) @(negedge clk);
    check_counts("after reset");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule